// File: doc/BRIEF.md
# Input DMA Buffer Pointer Handoff

This block keeps the buffer pointers for the capture (input) DMA path of an audio serial interface. Software places the byte address of the next capture buffer in a pending slot over a small register bus. The block keeps that value until the buffer now being filled is complete. It then loads the value into an active address counter and clears the slot. From that point the counter steps through the new buffer one 16-bit sample word at a time. Every handoff produces a one-cycle interrupt pulse, which tells software to supply the following pointer.

Software starts the block by writing the pointer once, then the buffer size, then the pointer again. The first pointer becomes the active buffer when a nonzero size is written. The second pointer waits in the slot. A block may not wrap the address space or touch its highest byte. A buffer may also complete while the slot is empty. In either case the block raises a sticky error flag, stops the counter and clears every channel enable, so a stale address is never reused.

The register bus has a write strobe, a byte offset and a combinational read port. The sample side gives one valid strobe per sample word. The block answers each accepted sample with a write request and the byte address for that sample.

Top module: `ain_ptr_handoff`

## Requirements
- R1: After reset, all four registers read zero: pending pointer at 0x20, size at 0x24, status at 0x28, channel enable at 0x2C. `mem_wreq`, `dma_in_irq` and `in_chan_en` are low.
- R2: A write to 0x20 stores a pending pointer, and the offset reads back the value last written. A second write before a handoff replaces the first.
- R3: A nonzero size is written to 0x24 while no buffer is active and a pointer is pending. That pointer becomes the active buffer, 0x20 then reads zero, and `dma_in_irq` pulses high for one cycle in the next cycle.
- R4: Each cycle with `smp_valid` high and an active buffer raises `mem_wreq` in that same cycle. `mem_addr` gives the current sample address, and the address then advances by 2 bytes.
- R5: After the configured number of samples the buffer completes. If a pointer is pending, the next sample goes to that pointer, `dma_in_irq` pulses once and 0x20 reads zero.
- R6: If a buffer completes with no pointer pending, status bit 0 (error) sets. Status bit 1 (active) clears, the channel enable register and `in_chan_en` go to zero, and further samples raise no `mem_wreq`.
- R7: A buffer whose last byte (base + 2*size - 1) reaches 0xFFFF or above is refused at handoff. It sets the error flag and gives no interrupt. A buffer whose last byte is 0xFFFD is accepted.
- R8: Writing a 1 to status bit 0 clears the error flag. Writing 0 leaves it set.
- R9: While the error flag is set, writes to 0x20, 0x24 and 0x2C are ignored.
- R10: Offset 0x2C bits [3:0] hold the channel enables, readable and writable. They drive `in_chan_en` directly.
- R11: Status bit 1 reads 1 exactly while a buffer is active.
- R12: Samples that arrive while no buffer is active are dropped and raise no `mem_wreq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| smp_valid | input | 1 | One captured sample word is ready |
| mem_wreq | output | 1 | Memory write request for the current sample |
| mem_addr | output | 32 | Byte address of the current sample |
| in_chan_en | output | 4 | Input channel enables |
| dma_in_irq | output | 1 | One-cycle pulse on each pointer handoff |

## Verification
Suppose the remaining-sample counter drifts or the address step is wrong. The scoreboard then sees a `mem_addr` mismatch on the very sample where the drift occurs, or an extra or missing request at the buffer boundary. Suppose instead the pending slot keeps a consumed value or loses its valid state. A read of 0x20 right after the interrupt returns nonzero, or a completion that should fail hands off silently. Both show up within one buffer length. A wrong range check shows up at the two boundary pointers, 0xFFF8 with four and with three samples, as an error flag in the wrong state.

// File: rtl/aip_pkg.sv
package aip_pkg;
  // register byte offsets; the pending pointer sits at 0x20
  localparam logic [7:0] OFS_NEXT = 8'h20;
  localparam logic [7:0] OFS_SIZE = 8'h24;
  localparam logic [7:0] OFS_STAT = 8'h28;
  localparam logic [7:0] OFS_CHEN = 8'h2C;

  // bytes per sample word
  localparam int SMP_BYTES = 2;

  // address of the last byte of a block of 'words' samples starting at 'base'
  function automatic logic [32:0] blk_last_byte(input logic [31:0] base,
                                                input logic [31:0] words);
    logic [32:0] span;
    span = {words, 1'b0};
    return {1'b0, base} + span - 33'd1;
  endfunction

  // a block is legal when nonempty and its last byte lies below the top address
  function automatic logic blk_fits(input logic [31:0] base,
                                    input logic [31:0] words,
                                    input int aw);
    logic [32:0] top;
    top = (33'd1 << aw) - 33'd1;
    return (words != 32'd0) && (blk_last_byte(base, words) < top);
  endfunction
endpackage

// File: rtl/aip_ptr_slot.sv
module aip_ptr_slot #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_val,
  input  logic          drop,
  output logic [PW-1:0] ptr,
  output logic          valid
);
  // a write in the same cycle as a drop re-arms the slot with the new value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      valid <= 1'b0;
    end else if (wr_en) begin
      ptr   <= wr_val;
      valid <= 1'b1;
    end else if (drop) begin
      ptr   <= '0;
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aip_addr_gen.sv
module aip_addr_gen #(
  parameter int PW   = 32,
  parameter int SZ_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PW-1:0]   load_base,
  input  logic [SZ_W-1:0] load_words,
  input  logic            step,
  output logic            active,
  output logic [PW-1:0]   addr,
  output logic            at_last
);
  import aip_pkg::*;

  localparam logic [PW-1:0]   STRIDE = PW'(SMP_BYTES);
  localparam logic [SZ_W-1:0] ONE    = SZ_W'(1);

  logic [SZ_W-1:0] rem;

  assign at_last = active && (rem == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr   <= '0;
      rem    <= '0;
    end else if (load) begin
      active <= 1'b1;
      addr   <= load_base;
      rem    <= load_words;
    end else if (step && active) begin
      addr <= addr + STRIDE;
      rem  <= rem - ONE;
      if (at_last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/aip_ctrl_regs.sv
module aip_ctrl_regs #(
  parameter int SZ_W = 12,
  parameter int NCH  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_size,
  input  logic [SZ_W-1:0] size_d,
  input  logic            wr_chen,
  input  logic [NCH-1:0]  chen_d,
  input  logic            clr_err,
  input  logic            set_err,
  output logic [SZ_W-1:0] size_q,
  output logic [NCH-1:0]  chen_q,
  output logic            err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      chen_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_size) size_q <= size_d;
      if (set_err) begin
        err_q  <= 1'b1;
        chen_q <= '0;
      end else begin
        if (clr_err) err_q <= 1'b0;
        if (wr_chen) chen_q <= chen_d;
      end
    end
  end
endmodule

// File: rtl/ain_ptr_handoff.sv
module ain_ptr_handoff #(
  parameter int AW   = 16,
  parameter int SZ_W = 12,
  parameter int NCH  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     reg_addr,
  input  logic           reg_wen,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           smp_valid,
  output logic           mem_wreq,
  output logic [31:0]    mem_addr,
  output logic [NCH-1:0] in_chan_en,
  output logic           dma_in_irq
);
  import aip_pkg::*;

  localparam int PW = 32;

  // named internal events
  logic            err_q, active, at_last, ptr_valid;
  logic [PW-1:0]   ptr_q, act_addr;
  logic [SZ_W-1:0] size_q, size_new, hand_words;
  logic [NCH-1:0]  chen_q;
  logic            wr_next, wr_size, wr_chen, clr_err;
  logic            start_req, sample_take, buf_done;
  logic            hand_try, hand_fits, hand_ok, hand_bad;
  logic            irq_q;

  // register decode; config writes are locked out while the error is set
  assign wr_next  = reg_wen && (reg_addr == OFS_NEXT) && !err_q;
  assign wr_size  = reg_wen && (reg_addr == OFS_SIZE) && !err_q;
  assign wr_chen  = reg_wen && (reg_addr == OFS_CHEN) && !err_q;
  assign clr_err  = reg_wen && (reg_addr == OFS_STAT) && reg_wdata[0];
  assign size_new = reg_wdata[SZ_W-1:0];

  // handoff events
  assign start_req   = wr_size && !active && ptr_valid && (size_new != '0);
  assign sample_take = smp_valid && active;
  assign buf_done    = sample_take && at_last;
  assign hand_try    = start_req || buf_done;
  assign hand_words  = start_req ? size_new : size_q;
  assign hand_fits   = ptr_valid && blk_fits(ptr_q, PW'(hand_words), AW);
  assign hand_ok     = hand_try && hand_fits;
  assign hand_bad    = hand_try && !hand_fits;

  aip_ptr_slot #(.PW(PW)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_next),
    .wr_val (reg_wdata),
    .drop   (hand_try),
    .ptr    (ptr_q),
    .valid  (ptr_valid)
  );

  aip_addr_gen #(.PW(PW), .SZ_W(SZ_W)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (hand_ok),
    .load_base  (ptr_q),
    .load_words (hand_words),
    .step       (sample_take),
    .active     (active),
    .addr       (act_addr),
    .at_last    (at_last)
  );

  aip_ctrl_regs #(.SZ_W(SZ_W), .NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_size (wr_size),
    .size_d  (size_new),
    .wr_chen (wr_chen),
    .chen_d  (reg_wdata[NCH-1:0]),
    .clr_err (clr_err),
    .set_err (hand_bad),
    .size_q  (size_q),
    .chen_q  (chen_q),
    .err_q   (err_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hand_ok;
  end

  assign dma_in_irq = irq_q;
  assign mem_wreq   = sample_take;
  assign mem_addr   = act_addr;
  assign in_chan_en = chen_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_NEXT: reg_rdata = ptr_q;
      OFS_SIZE: reg_rdata[SZ_W-1:0] = size_q;
      OFS_STAT: reg_rdata[1:0] = {active, err_q};
      OFS_CHEN: reg_rdata[NCH-1:0] = chen_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aip_checker.sv
module aip_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     reg_addr,
  input logic           reg_wen,
  input logic [31:0]    reg_wdata,
  input logic           irq,
  input logic           active,
  input logic           err,
  input logic [NCH-1:0] chen,
  input logic           wreq,
  input logic [31:0]    addr,
  input logic           at_last,
  input logic           hand_ok,
  input logic [31:0]    ptr_q,
  input logic           ptr_valid
);
  logic wr_next_raw, stat_clr;
  assign wr_next_raw = reg_wen && (reg_addr == 8'h20);
  assign stat_clr    = reg_wen && (reg_addr == 8'h28) && reg_wdata[0];

  // R3: an interrupt always comes with a live buffer
  a_r3_irq_has_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> active);

  // R5: a consumed slot reads empty unless refilled in the same cycle
  a_r5_slot_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (hand_ok && !wr_next_raw) |=> (!ptr_valid && ptr_q == 32'd0));

  // R4: address steps by one sample word inside a buffer
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq && !at_last) |=> (addr == $past(addr) + 32'd2));

  // R6: entering error stops the buffer and the channels
  a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!active && chen == '0));

  // R12: no request without a live buffer
  a_r12_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    wreq |-> (active && !err));

  // R8: error holds until a write of 1 to its bit
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !stat_clr) |=> err);

  // R9: config frozen while in error
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !stat_clr) |=> ($stable(ptr_q) && $stable(chen)));
endmodule

bind ain_ptr_handoff aip_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wen   (reg_wen),
  .reg_wdata (reg_wdata),
  .irq       (dma_in_irq),
  .active    (active),
  .err       (err_q),
  .chen      (chen_q),
  .wreq      (mem_wreq),
  .addr      (mem_addr),
  .at_last   (at_last),
  .hand_ok   (hand_ok),
  .ptr_q     (ptr_q),
  .ptr_valid (ptr_valid)
);

// File: tb/ain_ptr_handoff_bench.sv
`timescale 1ns/1ps
module ain_ptr_handoff_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        smp_valid = 1'b0;
  logic        mem_wreq;
  logic [31:0] mem_addr;
  logic [3:0]  in_chan_en;
  logic        dma_in_irq;

  always #4 clk = ~clk;

  ain_ptr_handoff u_ain_ptr_handoff (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .mem_wreq(mem_wreq), .mem_addr(mem_addr), .in_chan_en(in_chan_en),
    .dma_in_irq(dma_in_irq)
  );

  int n_run = 0, n_fail = 0, irq_seen = 0, m_irq = 0;
  logic [31:0] exp_q[$];

  // reference model state, built from the requirements
  logic        m_active = 0, m_err = 0, m_pv = 0;
  logic [31:0] m_pend = 0, m_addr = 0;
  int          m_rem = 0, m_size = 0;
  logic [3:0]  m_chen = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [31:0] base, input int words);
    longint last;
    last = longint'(base) + 2 * longint'(words) - 1;
    return (words > 0) && (last <= 64'hFFFE);
  endfunction

  task automatic try_hand(input int words);
    if (m_pv && legal(m_pend, words)) begin
      m_active = 1; m_addr = m_pend; m_rem = words; m_irq++;
    end else begin
      m_err = 1; m_active = 0; m_chen = 0;
    end
    m_pv = 0; m_pend = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    case (a)
      8'h20: if (!m_err) begin m_pend = d; m_pv = 1; end
      8'h24: if (!m_err) begin
               m_size = int'(d[11:0]);
               if (!m_active && m_pv && m_size != 0) try_hand(m_size);
             end
      8'h28: if (d[0]) m_err = 0;
      8'h2C: if (!m_err) m_chen = d[3:0];
      default: ;
    endcase
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // driver: presents samples and pushes the addresses the model expects
  task automatic samples(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      smp_valid = 1'b1;
      if (m_active && !m_err) begin
        exp_q.push_back(m_addr);
        m_addr = m_addr + 2;
        m_rem--;
        if (m_rem == 0) begin
          m_active = 0;
          try_hand(m_size);
        end
      end
    end
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  // monitor: pops expected addresses, counts interrupts
  always @(negedge clk) begin
    if (rst_n) begin
      if (dma_in_irq) irq_seen++;
      if (mem_wreq) begin
        if (exp_q.size() == 0) chk("R12 unexpected wreq", mem_addr, 32'hxxxxxxxx);
        else chk("R4 sample address", mem_addr, exp_q.pop_front());
      end
    end
  end

  task automatic check_regs(input string tag);
    logic [31:0] d;
    rd(8'h20, d); chk({tag, " next ptr"}, d, m_pend);
    rd(8'h24, d); chk({tag, " size"}, d, 32'(m_size));
    rd(8'h28, d); chk({tag, " status"}, d, {30'd0, m_active, m_err});
    rd(8'h2C, d); chk({tag, " chan"}, d, {28'd0, m_chen});
    chk({tag, " in_chan_en"}, {28'd0, in_chan_en}, {28'd0, m_chen});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 wreq", {31'd0, mem_wreq}, 32'd0);
    chk("R1 irq", {31'd0, dma_in_irq}, 32'd0);
    check_regs("R1");

    // R12 samples while idle are dropped
    samples(3);
    chk("R12 queue", 32'(exp_q.size()), 32'd0);

    // R2 write, readback, replace
    wr(8'h20, 32'h1100);
    check_regs("R2 first");
    wr(8'h20, 32'h1000);
    check_regs("R2 replaced");

    // R10 channel enables
    wr(8'h2C, 32'h5);
    check_regs("R10");

    // R3 startup handoff
    wr(8'h24, 32'd4);
    repeat (2) @(posedge clk);
    chk("R3 irq count", 32'(irq_seen), 32'(m_irq));
    check_regs("R3 R11");

    // R5 handoff at completion with a pending pointer
    wr(8'h20, 32'h2000);
    samples(6);
    repeat (2) @(posedge clk);
    chk("R5 irq count", 32'(irq_seen), 32'(m_irq));
    check_regs("R5");

    // R2 replace while a buffer runs, then complete into the replacement
    wr(8'h20, 32'h3000);
    wr(8'h20, 32'h3010);
    samples(3);
    check_regs("R5 second");

    // R6 completion with an empty slot
    samples(4);
    repeat (2) @(posedge clk);
    check_regs("R6");
    samples(2);
    chk("R6 queue", 32'(exp_q.size()), 32'd0);

    // R9 writes ignored during error
    wr(8'h20, 32'h4000);
    wr(8'h24, 32'd8);
    wr(8'h2C, 32'hF);
    check_regs("R9");

    // R8 write 0 keeps, write 1 clears
    wr(8'h28, 32'h0);
    check_regs("R8 keep");
    wr(8'h28, 32'h1);
    check_regs("R8 clear");

    // R7 block touching 0xFFFF refused, no interrupt
    wr(8'h20, 32'hFFF8);
    wr(8'h24, 32'd4);
    repeat (2) @(posedge clk);
    chk("R7 irq count", 32'(irq_seen), 32'(m_irq));
    check_regs("R7 refused");
    wr(8'h28, 32'h1);

    // R7 block ending at 0xFFFD accepted
    wr(8'h20, 32'hFFF8);
    wr(8'h24, 32'd3);
    repeat (2) @(posedge clk);
    chk("R7 ok irq count", 32'(irq_seen), 32'(m_irq));
    check_regs("R7 accepted");
    samples(3);
    repeat (2) @(posedge clk);
    check_regs("R6 after edge block");
    chk("R4 queue drained", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule